// File: doc/BRIEF.md
# Banked SPI register sequencer

This block turns single register and buffer requests from a host into framed SPI master transactions for a peripheral whose control registers are spread over four banks. Each request is one register read, register write, bit-set, bit-clear, 16-bit pair write, buffer read stream or buffer write stream. The block builds the command byte, shifts the frame out in SPI mode 0 with the most significant bit first, and returns read data on a one-cycle completion pulse.

The block keeps a copy of the bank that is currently selected in the peripheral. A register request whose bank differs from that copy is preceded by two frames: one clears both bank-select bits of a control register that every bank shares, and one sets the new bank value. Reads of the slow register class (address bit 7 set) clock one extra dummy byte before the byte that is returned. The SPI clock is the system clock divided by an even parameter. No request is accepted until the current one, including any bank switch, has finished.

Top module: `spi_bank_seq`

## Requirements
- R1: Every frame holds `cs_n` low from before the first rising SCK edge until after the last falling edge, SCK rests low whenever `cs_n` is high, and `cs_n` stays high for at least DIV system cycles between two frames.
- R2: Frames use SPI mode 0 with 8-bit bytes sent most significant bit first: MOSI is stable at each rising SCK edge and MISO is sampled on that edge.
- R3: The command byte of a register frame is the 3-bit opcode in bits 7:5 and address bits 4:0 in bits 4:0, with opcodes read 000, write 010, bit-set 100 and bit-clear 101; write, bit-set and bit-clear frames carry `req_data[7:0]` as their one data byte.
- R4: A register read sends the command byte then 0x00 bytes; with address bit 7 clear it returns the byte received right after the command, with bit 7 set it clocks one dummy byte and returns the byte after it on `done_rdata`.
- R5: When address bits 6:5 of a register request differ from the cached bank, the block first sends frame {0xBF, 0x03} (clear bank bits of control register 0x1F) then frame {0x9F, bank} (set the new bank), and then the requested frame(s).
- R6: After reset the cached bank is invalid, so the first register request performs the switch of R5 even when it targets bank 0.
- R7: A register request whose bank equals the cached bank sends no switch frames.
- R8: A pair write (op 4) sends two frames: write command to the address with `req_data[7:0]`, then write command to the address plus one (low 5 bits wrapping) with `req_data[15:8]`, with no switch frames between them.
- R9: A buffer read stream (op 5) sends command 0x3A then `req_len` bytes of 0x00 in one frame, and presents each received byte in order on `stm_rdata` with a one-cycle `stm_rvalid`; a length of zero sends only the command byte.
- R10: A buffer write stream (op 6) sends command 0x7A then `req_len` bytes in one frame, loading each from `stm_wdata` and pulsing `stm_take` once per byte loaded; buffer streams neither switch banks nor alter the cached bank.
- R11: `req_ready` is high only when the block is idle; `req_valid` while not ready starts nothing; `done` pulses for one cycle with the block idle again, carrying the read byte for op 0 and 0x00 for all other ops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_op | input | 3 | 0 read, 1 write, 2 bit-set, 3 bit-clear, 4 pair write, 5 buffer read, 6 buffer write |
| req_addr | input | 8 | Register address: bit 7 slow class, bits 6:5 bank, bits 4:0 register |
| req_data | input | 16 | Write data; high byte used only by pair write |
| req_len | input | LEN_W | Byte count of a buffer stream |
| stm_wdata | input | 8 | Next byte of a buffer write stream |
| stm_take | output | 1 | Pulse: one stream byte was loaded, present the next |
| stm_rvalid | output | 1 | Pulse: `stm_rdata` holds a received stream byte |
| stm_rdata | output | 8 | Received buffer stream byte |
| done | output | 1 | Pulse: request finished |
| done_rdata | output | 8 | Read result of the finished request |
| sck | output | 1 | SPI clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |

## Verification
The hardest situation to reach from the ports is a request arriving while the sequencer is between the frames of a bank switch, where a careless accept would interleave two commands. The bench holds `req_valid` high with a different command for many cycles right after a bank-switching write has been accepted, then confirms that the frame log holds exactly the expected frames and no extra ones. A bench model of the peripheral answers every byte with a value derived from its frame and byte index, so dummy-byte skipping and stream ordering show up as wrong values, and a bench copy of the bank cache walks through invalid-after-reset, same bank, new bank, pair-write address wrap and buffer streams that must leave the cache untouched.

// File: rtl/sbs_pkg.sv
// Shared types and constants of the banked SPI register sequencer.
// Assumes the peripheral opcode sits in command bits 7:5 and the
// register number in bits 4:0.
package sbs_pkg;

    // Host request codes
    typedef enum logic [2:0] {
        OP_RD    = 3'd0,
        OP_WR    = 3'd1,
        OP_BSET  = 3'd2,
        OP_BCLR  = 3'd3,
        OP_WR16  = 3'd4,
        OP_BUFRD = 3'd5,
        OP_BUFWR = 3'd6
    } host_op_e;

    // Frame kinds a single request may expand into
    typedef enum logic [1:0] {
        FR_BCLR,
        FR_BSET,
        FR_MAIN,
        FR_HIGH
    } frame_e;

    // Peripheral opcodes (command bits 7:5)
    localparam logic [2:0] SPI_RD_REG = 3'b000;
    localparam logic [2:0] SPI_RD_BUF = 3'b001;
    localparam logic [2:0] SPI_WR_REG = 3'b010;
    localparam logic [2:0] SPI_WR_BUF = 3'b011;
    localparam logic [2:0] SPI_SET    = 3'b100;
    localparam logic [2:0] SPI_CLR    = 3'b101;

    // Fixed argument of buffer commands and the shared control register
    localparam logic [4:0] BUF_ARG   = 5'h1A;
    localparam logic [4:0] CTRL_ADDR = 5'h1F;
    localparam logic [7:0] BANK_MASK = 8'h03;

endpackage

// File: rtl/sbs_shifter.sv
// One-byte SPI mode 0 shifter, MSB first.
// A start pulse loads a byte; SCK stays low for HALF system cycles,
// high for HALF cycles, eight times. MISO is captured at each rising
// SCK transition and MOSI advances at each falling one. fin pulses at
// the edge where the last falling transition happens.
// Assumes start is only raised while no byte is in flight.
module sbs_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       fin,
    output logic [7:0] rx
);
    localparam int CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(HALF - 1);

    logic             active_q;
    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic [2:0]       bit_q;
    logic [CNT_W-1:0] cnt_q;
    logic             sck_q;
    logic             fin_q;

    // Half-period timing, bit shifting and capture of one byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            sh_q     <= 8'h00;
            rx_q     <= 8'h00;
            bit_q    <= 3'd0;
            cnt_q    <= '0;
            sck_q    <= 1'b0;
            fin_q    <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!active_q) begin
                if (start) begin
                    active_q <= 1'b1;
                    sh_q     <= tx;
                    bit_q    <= 3'd0;
                    cnt_q    <= '0;
                    sck_q    <= 1'b0;
                end
            end else if (cnt_q == CNT_END) begin
                cnt_q <= '0;
                if (!sck_q) begin
                    sck_q <= 1'b1;
                    rx_q  <= {rx_q[6:0], miso};
                end else begin
                    sck_q <= 1'b0;
                    sh_q  <= {sh_q[6:0], 1'b0};
                    bit_q <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        active_q <= 1'b0;
                        fin_q    <= 1'b1;
                    end
                end
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign sck  = sck_q;
    assign mosi = active_q ? sh_q[7] : 1'b0;
    assign fin  = fin_q;
    assign rx   = rx_q;

endmodule

// File: rtl/sbs_bank_cache.sv
// Copy of the bank currently selected in the peripheral.
// Holds an invalid code after reset so the first compare misses.
// Assumes update pulses once, at the end of a bank-set frame.
module sbs_bank_cache (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] bank_in,
    input  logic       update,
    output logic       hit
);
    // Bit 2 set marks the copy as invalid
    logic [2:0] cached_q;

    // Record the bank once the switch frames have gone out
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cached_q <= 3'b111;
        end else if (update) begin
            cached_q <= {1'b0, bank_in};
        end
    end

    assign hit = (cached_q == {1'b0, bank_in});

endmodule

// File: rtl/sbs_frame_fmt.sv
// Combinational frame builder: for the frame kind and request in
// progress it gives the command byte, the byte sent after it, the
// number of bytes after the command, and how received bytes are used.
// Assumes the request fields are held stable for the whole request.
module sbs_frame_fmt
    import sbs_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  frame_e           frame,
    input  host_op_e         op,
    input  logic             slow,
    input  logic [4:0]       reg_lo,
    input  logic [15:0]      wdata,
    input  logic [1:0]       bank,
    input  logic [LEN_W-1:0] len,
    input  logic [7:0]       strm_byte,
    output logic [7:0]       cmd,
    output logic [7:0]       arg,
    output logic [LEN_W:0]   n_after,
    output logic             cap_last,
    output logic             strm_rd,
    output logic             strm_wr
);
    localparam logic [LEN_W:0] ONE = (LEN_W + 1)'(1);
    localparam logic [LEN_W:0] TWO = (LEN_W + 1)'(2);

    logic [4:0] reg_next;
    assign reg_next = reg_lo + 5'd1;

    // Select command, payload and length per frame kind and request
    always_comb begin
        cmd      = 8'h00;
        arg      = 8'h00;
        n_after  = ONE;
        cap_last = 1'b0;
        strm_rd  = 1'b0;
        strm_wr  = 1'b0;
        unique case (frame)
            FR_BCLR: begin
                cmd = {SPI_CLR, CTRL_ADDR};
                arg = BANK_MASK;
            end
            FR_BSET: begin
                cmd = {SPI_SET, CTRL_ADDR};
                arg = {6'b0, bank};
            end
            FR_HIGH: begin
                cmd = {SPI_WR_REG, reg_next};
                arg = wdata[15:8];
            end
            FR_MAIN: begin
                case (op)
                    OP_WR, OP_WR16: begin
                        cmd = {SPI_WR_REG, reg_lo};
                        arg = wdata[7:0];
                    end
                    OP_BSET: begin
                        cmd = {SPI_SET, reg_lo};
                        arg = wdata[7:0];
                    end
                    OP_BCLR: begin
                        cmd = {SPI_CLR, reg_lo};
                        arg = wdata[7:0];
                    end
                    OP_BUFRD: begin
                        cmd     = {SPI_RD_BUF, BUF_ARG};
                        n_after = {1'b0, len};
                        strm_rd = 1'b1;
                    end
                    OP_BUFWR: begin
                        cmd     = {SPI_WR_BUF, BUF_ARG};
                        arg     = strm_byte;
                        n_after = {1'b0, len};
                        strm_wr = 1'b1;
                    end
                    default: begin
                        cmd      = {SPI_RD_REG, reg_lo};
                        n_after  = slow ? TWO : ONE;
                        cap_last = 1'b1;
                    end
                endcase
            end
        endcase
    end

endmodule

// File: rtl/spi_bank_seq.sv
// Banked SPI register sequencer (top).
// Accepts one request at a time on a valid/ready port, expands it into
// optional bank-switch frames plus one or two operation frames, and
// runs each frame with chip select setup, byte shifting, hold and an
// inter-frame gap of one SCK period. done pulses when the block is idle.
// Assumes DIV is even and at least 2.
module spi_bank_seq
    import sbs_pkg::*;
#(
    parameter int DIV   = 4,
    parameter int LEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [7:0]       req_addr,
    input  logic [15:0]      req_data,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       stm_wdata,
    output logic             stm_take,
    output logic             stm_rvalid,
    output logic [7:0]       stm_rdata,
    output logic             done,
    output logic [7:0]       done_rdata,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int HALF  = DIV / 2;
    localparam int TMR_W = $clog2(DIV);
    localparam logic [TMR_W-1:0] HALF_END = TMR_W'(HALF - 1);
    localparam logic [TMR_W-1:0] GAP_END  = TMR_W'(DIV - 1);

    typedef enum logic [2:0] {
        S_IDLE,
        S_SETUP,
        S_BYTE,
        S_WAIT,
        S_HOLD,
        S_GAP
    } seq_state_e;

    seq_state_e       state_q;
    host_op_e         op_q;
    host_op_e         req_op_e;
    logic [7:0]       addr_q;
    logic [15:0]      data_q;
    logic [LEN_W-1:0] len_q;
    frame_e           frame_q;
    logic [LEN_W:0]   idx_q;
    logic [TMR_W-1:0] tmr_q;
    logic [7:0]       rd_q;
    logic             done_q;
    logic [7:0]       done_rdata_q;
    logic             take_q;
    logic             rvalid_q;
    logic [7:0]       rdata_q;

    logic [7:0]       f_cmd;
    logic [7:0]       f_arg;
    logic [LEN_W:0]   f_n_after;
    logic             f_cap_last;
    logic             f_strm_rd;
    logic             f_strm_wr;

    logic [1:0]       bank_sel;
    logic             bank_hit;
    logic             bank_upd;
    logic             req_is_reg;
    logic             sh_start;
    logic [7:0]       sh_tx;
    logic             sh_fin;
    logic [7:0]       sh_rx;

    assign req_op_e   = host_op_e'(req_op);
    assign req_is_reg = (req_op_e != OP_BUFRD) && (req_op_e != OP_BUFWR);

    // Bank compared: the incoming request while idle, the latched one after
    assign bank_sel = (state_q == S_IDLE) ? req_addr[6:5] : addr_q[6:5];
    assign bank_upd = (state_q == S_GAP) && (tmr_q == GAP_END) && (frame_q == FR_BSET);

    sbs_bank_cache u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .bank_in (bank_sel),
        .update  (bank_upd),
        .hit     (bank_hit)
    );

    sbs_frame_fmt #(
        .LEN_W (LEN_W)
    ) u_fmt (
        .frame     (frame_q),
        .op        (op_q),
        .slow      (addr_q[7]),
        .reg_lo    (addr_q[4:0]),
        .wdata     (data_q),
        .bank      (addr_q[6:5]),
        .len       (len_q),
        .strm_byte (stm_wdata),
        .cmd       (f_cmd),
        .arg       (f_arg),
        .n_after   (f_n_after),
        .cap_last  (f_cap_last),
        .strm_rd   (f_strm_rd),
        .strm_wr   (f_strm_wr)
    );

    assign sh_start = (state_q == S_BYTE);
    assign sh_tx    = (idx_q == '0) ? f_cmd : f_arg;

    sbs_shifter #(
        .HALF (HALF)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (sh_start),
        .tx    (sh_tx),
        .miso  (miso),
        .sck   (sck),
        .mosi  (mosi),
        .fin   (sh_fin),
        .rx    (sh_rx)
    );

    // Request sequencing: accept, frame setup, bytes, hold, gap, next frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= S_IDLE;
            op_q         <= OP_RD;
            addr_q       <= 8'h00;
            data_q       <= 16'h0000;
            len_q        <= '0;
            frame_q      <= FR_MAIN;
            idx_q        <= '0;
            tmr_q        <= '0;
            rd_q         <= 8'h00;
            done_q       <= 1'b0;
            done_rdata_q <= 8'h00;
            take_q       <= 1'b0;
            rvalid_q     <= 1'b0;
            rdata_q      <= 8'h00;
        end else begin
            done_q   <= 1'b0;
            take_q   <= 1'b0;
            rvalid_q <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        op_q    <= req_op_e;
                        addr_q  <= req_addr;
                        data_q  <= req_data;
                        len_q   <= req_len;
                        rd_q    <= 8'h00;
                        tmr_q   <= '0;
                        frame_q <= (req_is_reg && !bank_hit) ? FR_BCLR : FR_MAIN;
                        state_q <= S_SETUP;
                    end
                end
                S_SETUP: begin
                    if (tmr_q == HALF_END) begin
                        tmr_q   <= '0;
                        idx_q   <= '0;
                        state_q <= S_BYTE;
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                S_BYTE: begin
                    state_q <= S_WAIT;
                    if (f_strm_wr && (idx_q != '0)) begin
                        take_q <= 1'b1;
                    end
                end
                S_WAIT: begin
                    if (sh_fin) begin
                        if (f_strm_rd && (idx_q != '0)) begin
                            rvalid_q <= 1'b1;
                            rdata_q  <= sh_rx;
                        end
                        if (f_cap_last && (idx_q == f_n_after)) begin
                            rd_q <= sh_rx;
                        end
                        if (idx_q == f_n_after) begin
                            tmr_q   <= '0;
                            state_q <= S_HOLD;
                        end else begin
                            idx_q   <= idx_q + (LEN_W + 1)'(1);
                            state_q <= S_BYTE;
                        end
                    end
                end
                S_HOLD: begin
                    if (tmr_q == HALF_END) begin
                        tmr_q   <= '0;
                        state_q <= S_GAP;
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                S_GAP: begin
                    if (tmr_q == GAP_END) begin
                        tmr_q <= '0;
                        case (frame_q)
                            FR_BCLR: begin
                                frame_q <= FR_BSET;
                                state_q <= S_SETUP;
                            end
                            FR_BSET: begin
                                frame_q <= FR_MAIN;
                                state_q <= S_SETUP;
                            end
                            FR_MAIN: begin
                                if (op_q == OP_WR16) begin
                                    frame_q <= FR_HIGH;
                                    state_q <= S_SETUP;
                                end else begin
                                    done_q       <= 1'b1;
                                    done_rdata_q <= rd_q;
                                    state_q      <= S_IDLE;
                                end
                            end
                            default: begin
                                done_q       <= 1'b1;
                                done_rdata_q <= rd_q;
                                state_q      <= S_IDLE;
                            end
                        endcase
                    end else begin
                        tmr_q <= tmr_q + TMR_W'(1);
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign req_ready  = (state_q == S_IDLE);
    assign cs_n       = !(state_q inside {S_SETUP, S_BYTE, S_WAIT, S_HOLD});
    assign done       = done_q;
    assign done_rdata = done_rdata_q;
    assign stm_take   = take_q;
    assign stm_rvalid = rvalid_q;
    assign stm_rdata  = rdata_q;

endmodule

// File: rtl/sbs_checks.sv
// Protocol checker for spi_bank_seq, attached with bind.
// Watches only the block's ports; the chip-select gap is measured
// with a saturating counter instead of a long $past window.
module sbs_checks #(
    parameter int DIV = 4
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic req_ready,
    input logic done,
    input logic stm_take,
    input logic stm_rvalid
);
    localparam int GW = $clog2(DIV + 1) + 1;
    localparam logic [GW-1:0] GAP_MIN = GW'(DIV);

    logic [GW-1:0] high_cnt;

    // Count consecutive deselected cycles, saturating at DIV
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            high_cnt <= GAP_MIN;
        end else if (!cs_n) begin
            high_cnt <= '0;
        end else if (high_cnt < GAP_MIN) begin
            high_cnt <= high_cnt + GW'(1);
        end
    end

    AST_SCK_IDLE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck); // R1

    AST_CS_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (high_cnt >= GAP_MIN)); // R1

    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> !req_ready); // R11

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (req_ready && cs_n)); // R11

    AST_STREAM_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        !(stm_take && stm_rvalid)); // R9

    AST_STREAM_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (stm_take || stm_rvalid) |-> !cs_n); // R10

endmodule

bind spi_bank_seq sbs_checks #(.DIV(DIV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_n       (cs_n),
    .sck        (sck),
    .req_ready  (req_ready),
    .done       (done),
    .stm_take   (stm_take),
    .stm_rvalid (stm_rvalid)
);

// File: tb/spi_bank_seq_tb_top.sv
// Bench: a behavioural peripheral model answers on MISO and logs every
// frame; each clock it checks the chip-select and SCK rules, and after
// each request the logged frames and returned data are compared with
// frames computed from the requirements.
module spi_bank_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int LEN_W      = 8;
    localparam int LIMIT      = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_op = 3'd0;
    logic [7:0]       req_addr = 8'h00;
    logic [15:0]      req_data = 16'h0000;
    logic [LEN_W-1:0] req_len = '0;
    logic [7:0]       stm_wdata;
    logic             stm_take;
    logic             stm_rvalid;
    logic [7:0]       stm_rdata;
    logic             done;
    logic [7:0]       done_rdata;
    logic             sck;
    logic             cs_n;
    logic             mosi;
    logic             miso = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spi_bank_seq #(.DIV(DIV), .LEN_W(LEN_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_len(req_len),
        .stm_wdata(stm_wdata), .stm_take(stm_take), .stm_rvalid(stm_rvalid),
        .stm_rdata(stm_rdata), .done(done), .done_rdata(done_rdata),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    function automatic logic [7:0] resp(int f, int b);
        logic [7:0] fb = 8'(f);
        logic [7:0] bb = 8'(b);
        return 8'h96 ^ {fb[3:0], bb[3:0]};
    endfunction

    function automatic logic [7:0] pat(int i);
        return 8'(8'h3C + i * 7);
    endfunction

    // ---------------- peripheral model and frame log -----------------
    logic [7:0] gbyte [0:2047];
    int         glen  [0:255];
    int         gcount = 0;
    int         lcount = 0;
    int         proto_err = 0;
    logic       prev_sck = 1'b0;
    logic       prev_cs = 1'b1;
    int         gap = 100;
    int         fbytes = 0;
    int         mbit = 0;
    logic [7:0] msh = 8'h00;
    int         sf = 0;
    int         sb = 0;
    int         sbit = 0;
    logic [7:0] sreg = 8'h00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cs_n && sck) proto_err++;
            if (prev_cs && !cs_n) begin
                if (gap < DIV) proto_err++;
                fbytes = 0; mbit = 0; sb = 0; sbit = 0;
                sreg = resp(sf, 0);
                miso = sreg[7];
            end
            if (!cs_n && !prev_sck && sck) begin
                msh = {msh[6:0], mosi};
                mbit++;
                if (mbit == 8) begin
                    gbyte[gcount] = msh;
                    gcount++; fbytes++; mbit = 0;
                end
            end
            if (!cs_n && prev_sck && !sck) begin
                sbit++;
                if (sbit == 8) begin
                    sb++; sbit = 0; sreg = resp(sf, sb);
                end else begin
                    sreg = {sreg[6:0], 1'b0};
                end
                miso = sreg[7];
            end
            if (!prev_cs && cs_n) begin
                if (mbit != 0) proto_err++;
                glen[lcount] = fbytes;
                lcount++; sf++;
            end
            if (cs_n) gap = prev_cs ? gap + 1 : 1;
        end
        prev_sck = sck;
        prev_cs  = cs_n;
    end

    // ---------------- stream and completion capture -----------------
    logic [7:0] rd_log [0:255];
    int         rcount = 0;
    int         widx = 0;
    int         done_cnt = 0;
    logic [7:0] done_val = 8'h00;

    initial stm_wdata = pat(0);

    always @(negedge clk) begin
        if (stm_take) begin
            widx++;
            stm_wdata = pat(widx);
        end
        if (stm_rvalid) begin
            rd_log[rcount] = stm_rdata;
            rcount++;
        end
        if (done) begin
            done_cnt++;
            done_val = done_rdata;
        end
    end

    // ---------------- checks and expected frames -----------------
    int   errors = 0;
    int   checks = 0;
    int   exp_lens[$];
    logic [7:0] exp_bytes[$];
    int   nexp = 0;
    int   lc = 0;
    int   bc = 0;
    int   bank_m = -1;
    logic wd_hit = 1'b0;

    task automatic check(bit ok, string tag, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic add2(int a, int b);
        exp_lens.push_back(2);
        exp_bytes.push_back(8'(a));
        exp_bytes.push_back(8'(b));
        nexp++;
    endtask

    task automatic run_req(int op, int addr, int data, int len, bit spam, string tag);
        int d0 = done_cnt;
        int r0 = rcount;
        int w0 = widx;
        int n0 = nexp;
        int fi = 0;
        int a5 = addr & 'h1F;
        logic [7:0] exp_rd = 8'h00;
        int nf;
        if (op <= 4) begin
            int b = (addr >> 5) & 3;
            if (bank_m != b) begin
                add2('hBF, 'h03);
                add2('h9F, b);
                bank_m = b;
            end
        end
        case (op)
            0: begin
                fi = nexp;
                exp_bytes.push_back(8'(a5));
                exp_bytes.push_back(8'h00);
                if ((addr & 'h80) != 0) begin
                    exp_bytes.push_back(8'h00);
                    exp_lens.push_back(3);
                    exp_rd = resp(fi, 2);
                end else begin
                    exp_lens.push_back(2);
                    exp_rd = resp(fi, 1);
                end
                nexp++;
            end
            1: add2('h40 | a5, data & 'hFF);
            2: add2('h80 | a5, data & 'hFF);
            3: add2('hA0 | a5, data & 'hFF);
            4: begin
                add2('h40 | a5, data & 'hFF);
                add2('h40 | ((a5 + 1) & 'h1F), (data >> 8) & 'hFF);
            end
            5, 6: begin
                fi = nexp;
                exp_lens.push_back(len + 1);
                exp_bytes.push_back(op == 5 ? 8'h3A : 8'h7A);
                for (int i = 0; i < len; i++)
                    exp_bytes.push_back(op == 5 ? 8'h00 : pat(w0 + i));
                nexp++;
            end
            default: ;
        endcase
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_addr  = 8'(addr);
        req_data  = 16'(data);
        req_len   = LEN_W'(len);
        @(negedge clk);
        if (spam) begin
            req_op   = 3'd0;
            req_addr = 8'h80;
            repeat (20) @(negedge clk);
        end
        req_valid = 1'b0;
        while (done_cnt == d0) @(negedge clk);
        check(done_val == exp_rd, {tag, " done_rdata"}, done_val, exp_rd);
        nf = nexp - n0;
        check(lcount - lc == nf, {tag, " frame count"}, lcount - lc, nf);
        if (lcount - lc == nf) begin
            for (int k = 0; k < nf; k++) begin
                int L = exp_lens.pop_front();
                int act = glen[lc];
                int expv = L;
                bit ok = (glen[lc] == L);
                for (int j = 0; j < L; j++) begin
                    logic [7:0] eb = exp_bytes.pop_front();
                    if (ok && gbyte[bc + j] != eb) begin
                        ok = 1'b0; act = gbyte[bc + j]; expv = eb;
                    end
                end
                check(ok, {tag, " frame content"}, act, expv);
                bc += glen[lc];
                lc++;
            end
        end else begin
            for (int k = 0; k < nf; k++) begin
                int L = exp_lens.pop_front();
                for (int j = 0; j < L; j++) void'(exp_bytes.pop_front());
            end
            lc = lcount;
            bc = gcount;
        end
        if (op == 5) begin
            check(rcount - r0 == len, {tag, " stream read count"}, rcount - r0, len);
            for (int i = 0; i < len && r0 + i < rcount; i++)
                check(rd_log[r0 + i] == resp(fi, i + 1), {tag, " stream read byte"},
                      rd_log[r0 + i], resp(fi, i + 1));
        end
        if (op == 6)
            check(widx - w0 == len, {tag, " stream take count"}, widx - w0, len);
    endtask

    task automatic run_all();
        check(cs_n == 1'b1 && sck == 1'b0, "R1 reset idle lines", {cs_n, sck}, 2);
        check(req_ready == 1'b1 && done == 1'b0, "R11 reset handshake", {req_ready, done}, 2);
        run_req(1, 'h05, 'h44,   0, 1'b0, "R6 first access switches to bank 0");
        run_req(1, 'h25, 'h5A,   0, 1'b0, "R5 switch to bank 1, R3 write");
        run_req(0, 'h32, 0,      0, 1'b0, "R7 same bank read, R4 no dummy");
        run_req(0, 'hC4, 0,      0, 1'b0, "R4 slow read dummy, R5 bank 2");
        run_req(2, 'h5B, 'h21,   0, 1'b0, "R3 bit-set, R7 no switch");
        run_req(3, 'h7F, 'h81,   0, 1'b0, "R3 bit-clear, R5 bank 3");
        run_req(4, 'h7E, 'hBEEF, 0, 1'b0, "R8 pair write");
        run_req(4, 'h1F, 'h1234, 0, 1'b0, "R8 pair write address wrap");
        run_req(5, 0,    0,      5, 1'b0, "R9 buffer read, R2 bit order");
        run_req(6, 0,    0,      4, 1'b0, "R10 buffer write");
        run_req(0, 'h0A, 0,      0, 1'b0, "R10 cache kept after streams");
        run_req(5, 0,    0,      0, 1'b0, "R9 zero length stream");
        run_req(1, 'h46, 'h99,   0, 1'b1, "R11 request while busy ignored");
        repeat (4 * DIV) @(negedge clk);
        check(lcount == lc, "R11 no frame after busy request", lcount, lc);
        check(cs_n == 1'b1 && req_ready == 1'b1, "R11 idle after run", {cs_n, req_ready}, 3);
        check(proto_err == 0, "R1 R2 chip select and clock rules", proto_err, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_all();
            begin
                repeat (LIMIT) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=hang expected=done");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule